// File: doc/BRIEF.md
# Timer Compare Match Unit

This block holds a timer count and compares it, on every timer tick, against two compare values. It can work as a narrow timer with two independent 8-bit compare channels, or as a single 16-bit timer with one compare channel. A detected equality is registered and turns into a sticky status flag on the following tick. Each flag drives an interrupt request line when that flag's enable bit is set. A flag is cleared either by the interrupt acknowledge for its channel or by a write-one-to-clear access from the CPU.

The CPU reaches the block through a byte-wide write port. A write to either half of the count arms a one-shot suppression. The next tick then detects no equality, even when the timer has been stopped for any length of time before that tick. Software can therefore load the count with the same value as a compare register without raising a spurious flag.

Register addresses (3-bit `wr_addr`): 0 loads the count, 1 holds the pending upper count byte, 2 and 3 are the low and high bytes of compare value A, 4 is compare value B, 5 clears flags, and 6 holds the interrupt enables. In registers 5 and 6, bit 0 belongs to channel A and bit 1 to channel B.

Top module: `tmr_cmp_unit`

## Requirements
- R1: Each cycle with `tick` high advances the count by one. In 16-bit mode (`mode16`=1) the whole count carries, so 0x00FF goes to 0x0100. In 8-bit mode only the low byte wraps (0xFF goes to 0x00) and the high byte is held. A count load in the same cycle takes priority over the advance.
- R2: An equality seen on one tick sets its flag on the next tick, not earlier.
- R3: In 8-bit mode, the count low byte equal to compare A low byte sets flag A (bit 0). The count low byte equal to compare B sets flag B (bit 1).
- R4: In 16-bit mode, only the full 16-bit count equal to the 16-bit compare A sets flag A. Compare B never sets flag B.
- R5: `irq_a` is high exactly while flag A and enable bit 0 are both set. `irq_b` follows flag B and enable bit 1 in the same way.
- R6: A pulse on `ack_a` or `ack_b` clears that flag. Writing 1 to a bit of address 5 clears that flag, and writing 0 to a bit leaves it unchanged.
- R7: A write to address 0 or 1 suppresses any equality on the next tick. This holds however many cycles pass without a tick in between.
- R8: When a flag set and a clear fall in the same cycle, the flag ends up set.
- R9: After reset the count, compare values, flags, enables, pending equalities and suppression state are all zero.
- R10: A write to address 1 only stores the upper byte. A write to address 0 loads the count as {stored upper byte, written byte}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer clock enable, one cycle per timer step |
| mode16 | input | 1 | 1 = single 16-bit timer, 0 = 8-bit timer with two channels |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 3 | CPU register address |
| wr_data | input | 8 | CPU write data |
| ack_a | input | 1 | Interrupt acknowledge for channel A |
| ack_b | input | 1 | Interrupt acknowledge for channel B |
| cnt_q | output | 16 | Current count |
| flag_a | output | 1 | Compare flag A |
| flag_b | output | 1 | Compare flag B |
| irq_a | output | 1 | Interrupt request A |
| irq_b | output | 1 | Interrupt request B |

## Verification
The in-design properties assume two things about the inputs. First, `mode16` does not change between a tick and the tick after it. Second, `tick` stays low while reset is asserted. The stimulus changes the mode only between sequences, and only after enough ticks that no equality is still pending. It also keeps every input low during reset. Ticks and CPU writes are otherwise mixed freely, including a tick that coincides with a flag clear, so that the set-over-clear rule is exercised.

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          mode16,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          ack_a,
  input  logic          ack_b,
  output logic [2*DW-1:0] cnt_q,
  output logic          flag_a,
  output logic          flag_b,
  output logic          irq_a,
  output logic          irq_b
);
  localparam int CW = 2 * DW;
  localparam logic [AW-1:0] A_CNT_LO = AW'(0);
  localparam logic [AW-1:0] A_CNT_HI = AW'(1);
  localparam logic [AW-1:0] A_CMPA_L = AW'(2);
  localparam logic [AW-1:0] A_CMPA_H = AW'(3);
  localparam logic [AW-1:0] A_CMPB   = AW'(4);
  localparam logic [AW-1:0] A_FCLR   = AW'(5);
  localparam logic [AW-1:0] A_IEN    = AW'(6);

  logic [DW-1:0] hi_tmp, cmp_b;
  logic [CW-1:0] cmp_a;
  logic [1:0]    ien;
  logic          blk, pend_a, pend_b;

  wire lo_wr  = wr_en && wr_addr == A_CNT_LO;
  wire hi_wr  = wr_en && wr_addr == A_CNT_HI;
  wire cnt_wr = lo_wr || hi_wr;
  wire fclr   = wr_en && wr_addr == A_FCLR;

  wire match_a = mode16 ? (cnt_q == cmp_a) : (cnt_q[DW-1:0] == cmp_a[DW-1:0]);
  wire match_b = !mode16 && (cnt_q[DW-1:0] == cmp_b);
  wire set_a   = tick && pend_a;
  wire set_b   = tick && pend_b;
  wire clr_a   = ack_a || (fclr && wr_data[0]);
  wire clr_b   = ack_b || (fclr && wr_data[1]);

  assign irq_a = flag_a && ien[0];
  assign irq_b = flag_b && ien[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_tmp <= '0;
      cmp_a  <= '0;
      cmp_b  <= '0;
      ien    <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CNT_HI: hi_tmp <= wr_data;
        A_CMPA_L: cmp_a[DW-1:0] <= wr_data;
        A_CMPA_H: cmp_a[CW-1:DW] <= wr_data;
        A_CMPB:   cmp_b <= wr_data;
        A_IEN:    ien <= wr_data[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (lo_wr)
      cnt_q <= {hi_tmp, wr_data};
    else if (tick)
      cnt_q <= mode16 ? cnt_q + CW'(1) : {cnt_q[CW-1:DW], cnt_q[DW-1:0] + DW'(1)};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk    <= 1'b0;
      pend_a <= 1'b0;
      pend_b <= 1'b0;
    end else if (cnt_wr) begin
      blk    <= 1'b1;
      pend_a <= 1'b0;
      pend_b <= 1'b0;
    end else if (tick) begin
      blk    <= 1'b0;
      pend_a <= match_a && !blk;
      pend_b <= match_b && !blk;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_a <= 1'b0;
      flag_b <= 1'b0;
    end else begin
      if (set_a)      flag_a <= 1'b1;
      else if (clr_a) flag_a <= 1'b0;
      if (set_b)      flag_b <= 1'b1;
      else if (clr_b) flag_b <= 1'b0;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !lo_wr |=> cnt_q[DW-1:0] == $past(cnt_q[DW-1:0]) + DW'(1)); // R1
  AST_SET_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_a) |-> $past(tick)); // R2
  AST_B_SILENT_16: assert property (@(posedge clk) disable iff (!rst_n)
    tick && mode16 |=> !pend_b); // R4
  AST_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_a) |-> $past(ack_a || (wr_en && wr_addr == A_FCLR && wr_data[0]))); // R6
  AST_BLOCKED_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    tick && blk |=> !pend_a && !pend_b); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    tick && pend_a |=> flag_a); // R8
endmodule

// File: tb/tmr_cmp_unit_tb.sv
`timescale 1ns/1ps
module tmr_cmp_unit_tb;
  logic clk = 0, rst_n = 0, tick = 0, mode16 = 0, wr_en = 0, ack_a = 0, ack_b = 0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [15:0] cnt_q;
  logic flag_a, flag_b, irq_a, irq_b;

  tmr_cmp_unit u_dut (.clk, .rst_n, .tick, .mode16, .wr_en, .wr_addr, .wr_data,
                      .ack_a, .ack_b, .cnt_q, .flag_a, .flag_b, .irq_a, .irq_b);

  always #2 clk = ~clk;

  typedef struct { string tag; int sel; logic [15:0] exp; } item_t;
  item_t q[$];
  event chk_ev;
  int checks = 0, fails = 0;
  bit done = 0;

  initial forever begin
    @(chk_ev);
    while (q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      act = (it.sel == 0) ? {12'd0, irq_b, irq_a, flag_b, flag_a} : cnt_q;
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_v(string tag, int sel, logic [15:0] e);
    item_t it;
    it.tag = tag; it.sel = sel; it.exp = e;
    q.push_back(it);
    ->chk_ev;
    #1;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic tk(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1;
      @(posedge clk); @(negedge clk);
      tick = 0;
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_v("R9 reset flags/irqs", 0, 16'h0);
    expect_v("R9 reset count", 1, 16'h0);
    rst_n = 1;
    @(negedge clk);
    // 8-bit mode, channel A
    wr(2, 8'd5); wr(3, 8'd0); wr(1, 8'd0); wr(0, 8'd3);
    tk(3);
    expect_v("R2 flag not yet set after match tick", 0, 16'h0);
    tk(1);
    expect_v("R3 flag A set in 8-bit mode", 0, 16'h1);
    expect_v("R1 count after ticks", 1, 16'h0007);
    wr(5, 8'h00);
    expect_v("R6 write zero keeps flag", 0, 16'h1);
    wr(5, 8'h01);
    expect_v("R6 write one clears flag", 0, 16'h0);
    // blocking
    wr(4, 8'd9); wr(0, 8'd9);
    tk(3);
    expect_v("R7 write blocks next-tick match", 0, 16'h0);
    wr(0, 8'd9);
    repeat (6) @(negedge clk);
    tk(2);
    expect_v("R7 block holds while stopped", 0, 16'h0);
    wr(0, 8'd8);
    tk(3);
    expect_v("R3 flag B set in 8-bit mode", 0, 16'h2);
    // interrupts
    wr(6, 8'h02);
    expect_v("R5 irq_b with enable", 0, 16'ha);
    ack_b = 1; @(posedge clk); @(negedge clk); ack_b = 0;
    expect_v("R6 ack clears flag B", 0, 16'h0);
    // set wins
    wr(0, 8'd4);
    tk(2);
    tick = 1; wr_en = 1; wr_addr = 3'd5; wr_data = 8'h01;
    @(posedge clk); @(negedge clk);
    tick = 0; wr_en = 0;
    expect_v("R8 set beats clear", 0, 16'h1);
    wr(5, 8'h03);
    // 8-bit wrap and load
    wr(1, 8'h00); wr(0, 8'hFF);
    tk(1);
    expect_v("R1 8-bit wrap", 1, 16'h0000);
    wr(1, 8'h12);
    expect_v("R10 upper byte write alone", 1, 16'h0000);
    wr(0, 8'hFE);
    expect_v("R10 load on low write", 1, 16'h12FE);
    tk(2);
    expect_v("R1 high byte held in 8-bit mode", 1, 16'h1200);
    // 16-bit mode
    mode16 = 1;
    wr(2, 8'h05); wr(3, 8'h01); wr(4, 8'h05);
    wr(1, 8'h00); wr(0, 8'h04);
    tk(3);
    expect_v("R4 low-byte only and B give no flag", 0, 16'h0);
    wr(1, 8'h01); wr(0, 8'h03);
    tk(4);
    expect_v("R4 16-bit match sets flag A only", 0, 16'h1);
    expect_v("R1 16-bit count", 1, 16'h0107);
    wr(1, 8'h00); wr(0, 8'hFF);
    tk(1);
    expect_v("R1 16-bit carry", 1, 16'h0100);
    #1;
    ->chk_ev;
    #1;
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule